// File: doc/BRIEF.md
# Dual-Clock Elasticity Buffer with Framing-Character Rate Matching

This block sits between a receive channel's recovered clock and a local read clock. Each character arrives on the write clock with an 8-bit value and a 3-bit status code, and is stored in a ten-entry ring. The read side runs from a clock that may differ from the write clock in frequency and phase, or match it in frequency with unknown phase. The read side takes one character out on every read clock edge.

To keep the buffer near half full, the block only ever changes the stream at framing characters. A framing character has data 8'hBC and status 3'b001. When the write side sees the buffer filling up, it drops an incoming framing character. When the read side sees the buffer running low and a framing character is at the head, it emits one extra copy of that character and leaves the head where it is. If these adjustments cannot keep up, a sticky error flag is raised and the pointer of the side that saw the fault is moved back to the nominal spacing.

Pointers cross between the clock domains in a cyclic Gray code. The code covers twice the depth and is taken from the middle of a power-of-two code space. A bypass setting skips the ring: the output is then simply the input, registered once on the write clock.

Top module: `elastic_buf`

## Requirements
- R1: Characters that are not framing characters (status 3'b000) leave the buffer in the order they were written, with data and status unchanged. This holds when the read clock is slower than, equal to, or faster than the write clock.
- R2: While reset is held, the output shows the filler character (data 8'hBC, status 3'b001) and both error flags read 0. Reset fills all ten entries with the filler and places the write pointer NOMINAL (5) entries ahead of the read pointer.
- R3: A framing character (data 8'hBC, status 3'b001) that arrives while the write-side fill is 8 or more is discarded. With a slower read clock and framing on every second character, no overflow occurs and fewer framing characters come out than go in.
- R4: When the read-side fill is 2 or less and the head entry is a framing character, the output shows the filler and the head is kept. This happens at most once for each head entry. With a faster read clock and framing on every second character, no underflow occurs, runs of framing characters are at most 2 long, and more framing characters come out than go in.
- R5: A write that is not deleted, arriving when the write-side fill is 10, has these effects: ovf_err is set and stays set until reset, the character is dropped, and the write pointer is moved to NOMINAL entries ahead of the synchronised read pointer.
- R6: A read cycle in which the read-side fill is 0 has these effects: unf_err is set and stays set until reset, the output shows the filler, and the read pointer is moved to NOMINAL entries behind the synchronised write pointer.
- R7: With bypass high (changed only during reset), the output equals the input character registered once on the write clock. No entry is added, removed or stored, and both flags stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | A character is present on wr_data/wr_stat this cycle |
| wr_data | input | 8 | Decoded character value |
| wr_stat | input | 3 | Character status code |
| rclk | input | 1 | Local read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| bypass | input | 1 | Pass-through mode; static outside reset |
| rx_data | output | 8 | Output character value |
| rx_stat | output | 3 | Output character status |
| ovf_err | output | 1 | Sticky overflow flag (write domain) |
| unf_err | output | 1 | Sticky underflow flag (read domain) |

## Verification
The assertions check several things on every cycle. Each pointer's Gray code changes by at most one bit per step, except on a re-centring. The write-side fill never exceeds the depth. An insertion holds the read pointer and is never repeated on the next cycle. Both error flags are sticky. Bypass freezes both pointers. Only the bench scenarios can show the end-to-end properties. These are that every data character survives in order under slow, equal and fast read clocks, that deletion and insertion actually hold off overflow and underflow, and that the flags do rise when no framing characters are sent. They also show that bypass output is the input delayed by exactly one write clock.

// File: rtl/eb_pkg.sv
`timescale 1ns/1ps
package eb_pkg;
    localparam int CHAR_W = 8;
    localparam int STAT_W = 3;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [CHAR_W-1:0] data;
    } eb_char_t;

    localparam logic [STAT_W-1:0] ST_DATA    = 3'b000;
    localparam logic [STAT_W-1:0] ST_SPECIAL = 3'b001;
    localparam logic [CHAR_W-1:0] K28_5      = 8'hBC;
    localparam eb_char_t FILL_CHAR = '{stat: ST_SPECIAL, data: K28_5};

    function automatic logic is_framing(input eb_char_t c);
        return (c.stat == ST_SPECIAL) && (c.data == K28_5);
    endfunction
endpackage

// File: rtl/eb_ptr_sync.sv
`timescale 1ns/1ps
module eb_ptr_sync #(
    parameter int PW      = 5,
    parameter int OFS     = 6,
    parameter int STAGES  = 2,
    parameter int RST_PTR = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] ptr_out
);
    localparam logic [PW-1:0] RST_V = PW'(RST_PTR) + PW'(OFS);
    localparam logic [PW-1:0] RST_G = RST_V ^ (RST_V >> 1);

    logic [PW-1:0] stg [STAGES];
    logic [PW-1:0] bin;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_G;
        end else begin
            stg[0] <= gray_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    always_comb begin
        bin[PW-1] = stg[STAGES-1][PW-1];
        for (int i = PW-2; i >= 0; i--) bin[i] = bin[i+1] ^ stg[STAGES-1][i];
        ptr_out = bin - PW'(OFS);
    end
endmodule

// File: rtl/eb_store.sv
`timescale 1ns/1ps
module eb_store
    import eb_pkg::*;
#(
    parameter int DEPTH = 10,
    parameter int AW    = 4
) (
    input  logic          wclk,
    input  logic          wr_rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  eb_char_t      wdata,
    input  logic [AW-1:0] raddr,
    output eb_char_t      rdata
);
    eb_char_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_rst) mem[i] <= FILL_CHAR;
            else if (we && waddr == AW'(i)) mem[i] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eb_wr_ctl.sv
`timescale 1ns/1ps
module eb_wr_ctl
    import eb_pkg::*;
#(
    parameter int DEPTH   = 10,
    parameter int MOD     = 20,
    parameter int PW      = 5,
    parameter int OFS     = 6,
    parameter int AW      = 4,
    parameter int NOMINAL = 5,
    parameter int DEL_LVL = 8
) (
    input  logic          wclk,
    input  logic          wr_rst,
    input  logic          bypass,
    input  logic          wr_en,
    input  eb_char_t      wr_char,
    input  logic [PW-1:0] rptr_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wptr_g,
    output eb_char_t      byp_char,
    output logic          ovf_err
);
    localparam logic [PW:0]   MODX    = (PW+1)'(MOD);
    localparam logic [PW-1:0] NOM     = PW'(NOMINAL);
    localparam logic [PW-1:0] DEL_L   = PW'(DEL_LVL);
    localparam logic [PW-1:0] FULL    = PW'(DEPTH);
    localparam logic [PW-1:0] OFS_P   = PW'(OFS);

    function automatic logic [PW-1:0] ring_diff(input logic [PW-1:0] a, input logic [PW-1:0] b);
        logic [PW:0] t;
        t = {1'b0, a} + MODX - {1'b0, b};
        if (t >= MODX) t = t - MODX;
        return t[PW-1:0];
    endfunction

    function automatic logic [PW-1:0] ring_add(input logic [PW-1:0] a, input logic [PW-1:0] k);
        logic [PW:0] t;
        t = {1'b0, a} + {1'b0, k};
        if (t >= MODX) t = t - MODX;
        return t[PW-1:0];
    endfunction

    function automatic logic [PW-1:0] enc(input logic [PW-1:0] p);
        logic [PW-1:0] v;
        v = p + OFS_P;
        return v ^ (v >> 1);
    endfunction

    logic [PW-1:0] wptr, wptr_nx, wfill, slot;
    logic          frm, del, ovf_ev;

    always_comb begin
        wfill  = ring_diff(wptr, rptr_s);
        frm    = is_framing(wr_char);
        del    = wr_en && !bypass && frm && (wfill >= DEL_L);
        ovf_ev = wr_en && !bypass && !del && (wfill >= FULL);
        we     = wr_en && !bypass && !del && !ovf_ev;
        slot   = (wptr >= FULL) ? wptr - FULL : wptr;
        waddr  = slot[AW-1:0];
        if (ovf_ev)  wptr_nx = ring_add(rptr_s, NOM);
        else if (we) wptr_nx = ring_add(wptr, PW'(1));
        else         wptr_nx = wptr;
    end

    always_ff @(posedge wclk) begin
        if (wr_rst) begin
            wptr     <= NOM;
            wptr_g   <= enc(NOM);
            ovf_err  <= 1'b0;
            byp_char <= FILL_CHAR;
        end else begin
            wptr     <= wptr_nx;
            wptr_g   <= enc(wptr_nx);
            byp_char <= wr_char;
            if (ovf_ev) ovf_err <= 1'b1;
        end
    end

    // R1
    gray_step_w_chk: assert property (@(posedge wclk) disable iff (wr_rst)
        !ovf_ev |=> ($countones(wptr_g ^ $past(wptr_g)) <= 1));
    // R5
    fill_bound_w_chk: assert property (@(posedge wclk) disable iff (wr_rst)
        wfill <= FULL);
    // R5
    ovf_sticky_chk: assert property (@(posedge wclk) disable iff (wr_rst)
        ovf_err |=> ovf_err);
    // R3
    del_hold_chk: assert property (@(posedge wclk) disable iff (wr_rst)
        del |=> $stable(wptr));
    // R7
    byp_hold_w_chk: assert property (@(posedge wclk) disable iff (wr_rst)
        bypass |=> ($stable(wptr_g) && !ovf_err));
endmodule

// File: rtl/eb_rd_ctl.sv
`timescale 1ns/1ps
module eb_rd_ctl
    import eb_pkg::*;
#(
    parameter int DEPTH   = 10,
    parameter int MOD     = 20,
    parameter int PW      = 5,
    parameter int OFS     = 6,
    parameter int AW      = 4,
    parameter int NOMINAL = 5,
    parameter int INS_LVL = 2
) (
    input  logic          rclk,
    input  logic          rd_rst,
    input  logic          bypass,
    input  logic [PW-1:0] wptr_s,
    input  eb_char_t      head,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rptr_g,
    output eb_char_t      rd_char,
    output logic          unf_err
);
    localparam logic [PW:0]   MODX  = (PW+1)'(MOD);
    localparam logic [PW-1:0] NOM   = PW'(NOMINAL);
    localparam logic [PW-1:0] INS_L = PW'(INS_LVL);
    localparam logic [PW-1:0] FULL  = PW'(DEPTH);
    localparam logic [PW-1:0] OFS_P = PW'(OFS);

    function automatic logic [PW-1:0] ring_diff(input logic [PW-1:0] a, input logic [PW-1:0] b);
        logic [PW:0] t;
        t = {1'b0, a} + MODX - {1'b0, b};
        if (t >= MODX) t = t - MODX;
        return t[PW-1:0];
    endfunction

    function automatic logic [PW-1:0] ring_add(input logic [PW-1:0] a, input logic [PW-1:0] k);
        logic [PW:0] t;
        t = {1'b0, a} + {1'b0, k};
        if (t >= MODX) t = t - MODX;
        return t[PW-1:0];
    endfunction

    function automatic logic [PW-1:0] enc(input logic [PW-1:0] p);
        logic [PW-1:0] v;
        v = p + OFS_P;
        return v ^ (v >> 1);
    endfunction

    logic [PW-1:0] rptr, rptr_nx, rfill, slot;
    logic          ins_done, unf_ev, ins, pop;

    always_comb begin
        rfill  = ring_diff(wptr_s, rptr);
        unf_ev = !bypass && (rfill == '0);
        ins    = !bypass && !unf_ev && (rfill <= INS_L) && is_framing(head) && !ins_done;
        pop    = !bypass && !unf_ev && !ins;
        slot   = (rptr >= FULL) ? rptr - FULL : rptr;
        raddr  = slot[AW-1:0];
        if (unf_ev)   rptr_nx = ring_diff(wptr_s, NOM);
        else if (pop) rptr_nx = ring_add(rptr, PW'(1));
        else          rptr_nx = rptr;
    end

    always_ff @(posedge rclk) begin
        if (rd_rst) begin
            rptr     <= '0;
            rptr_g   <= enc('0);
            rd_char  <= FILL_CHAR;
            unf_err  <= 1'b0;
            ins_done <= 1'b0;
        end else if (!bypass) begin
            rptr     <= rptr_nx;
            rptr_g   <= enc(rptr_nx);
            rd_char  <= (unf_ev || ins) ? FILL_CHAR : head;
            ins_done <= ins;
            if (unf_ev) unf_err <= 1'b1;
        end
    end

    // R1
    gray_step_r_chk: assert property (@(posedge rclk) disable iff (rd_rst)
        !unf_ev |=> ($countones(rptr_g ^ $past(rptr_g)) <= 1));
    // R1
    fill_bound_r_chk: assert property (@(posedge rclk) disable iff (rd_rst)
        rfill <= FULL);
    // R4
    ins_hold_chk: assert property (@(posedge rclk) disable iff (rd_rst)
        ins |=> ($stable(rptr) && rd_char == FILL_CHAR));
    // R4
    ins_once_chk: assert property (@(posedge rclk) disable iff (rd_rst)
        ins |=> !ins);
    // R6
    unf_sticky_chk: assert property (@(posedge rclk) disable iff (rd_rst)
        unf_err |=> unf_err);
    // R7
    byp_hold_r_chk: assert property (@(posedge rclk) disable iff (rd_rst)
        bypass |=> $stable(rptr_g));
endmodule

// File: rtl/elastic_buf.sv
`timescale 1ns/1ps
module elastic_buf
    import eb_pkg::*;
#(
    parameter int DEPTH       = 10,
    parameter int NOMINAL     = 5,
    parameter int DEL_LVL     = 8,
    parameter int INS_LVL     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       wclk,
    input  logic       wr_rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [2:0] wr_stat,
    input  logic       rclk,
    input  logic       rd_rst,
    input  logic       bypass,
    output logic [7:0] rx_data,
    output logic [2:0] rx_stat,
    output logic       ovf_err,
    output logic       unf_err
);
    localparam int MOD = 2 * DEPTH;
    localparam int PW  = $clog2(MOD);
    localparam int OFS = ((1 << PW) - MOD) / 2;
    localparam int AW  = $clog2(DEPTH);

    eb_char_t      in_char, head, byp_char, rd_char, out_char;
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wptr_g, rptr_g, wptr_rs, rptr_ws;

    assign in_char  = '{stat: wr_stat, data: wr_data};
    assign out_char = bypass ? byp_char : rd_char;
    assign rx_data  = out_char.data;
    assign rx_stat  = out_char.stat;

    eb_wr_ctl #(.DEPTH(DEPTH), .MOD(MOD), .PW(PW), .OFS(OFS), .AW(AW),
                .NOMINAL(NOMINAL), .DEL_LVL(DEL_LVL)) u_wr (
        .wclk(wclk), .wr_rst(wr_rst), .bypass(bypass), .wr_en(wr_en),
        .wr_char(in_char), .rptr_s(rptr_ws), .we(we), .waddr(waddr),
        .wptr_g(wptr_g), .byp_char(byp_char), .ovf_err(ovf_err));

    eb_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk(wclk), .wr_rst(wr_rst), .we(we), .waddr(waddr),
        .wdata(in_char), .raddr(raddr), .rdata(head));

    eb_ptr_sync #(.PW(PW), .OFS(OFS), .STAGES(SYNC_STAGES), .RST_PTR(NOMINAL)) u_w2r (
        .clk(rclk), .rst(rd_rst), .gray_in(wptr_g), .ptr_out(wptr_rs));

    eb_ptr_sync #(.PW(PW), .OFS(OFS), .STAGES(SYNC_STAGES), .RST_PTR(0)) u_r2w (
        .clk(wclk), .rst(wr_rst), .gray_in(rptr_g), .ptr_out(rptr_ws));

    eb_rd_ctl #(.DEPTH(DEPTH), .MOD(MOD), .PW(PW), .OFS(OFS), .AW(AW),
                .NOMINAL(NOMINAL), .INS_LVL(INS_LVL)) u_rd (
        .rclk(rclk), .rd_rst(rd_rst), .bypass(bypass), .wptr_s(wptr_rs),
        .head(head), .raddr(raddr), .rptr_g(rptr_g), .rd_char(rd_char),
        .unf_err(unf_err));
endmodule

// File: tb/sim_elastic_buf.sv
`timescale 1ns/1ps
module sim_elastic_buf;
    import eb_pkg::*;

    localparam int NOM = 5;

    logic       wclk = 1'b0, rclk = 1'b0;
    logic       wr_rst, rd_rst, wr_en, bypass;
    logic [7:0] wr_data, rx_data;
    logic [2:0] wr_stat, rx_stat;
    logic       ovf_err, unf_err;
    real        rhalf = 2.5;

    initial forever #2.5 wclk = ~wclk;
    initial begin #1.1; forever #(rhalf) rclk = ~rclk; end

    elastic_buf u0 (
        .wclk(wclk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_stat(wr_stat), .rclk(rclk), .rd_rst(rd_rst), .bypass(bypass),
        .rx_data(rx_data), .rx_stat(rx_stat), .ovf_err(ovf_err), .unf_err(unf_err));

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // output monitor
    bit mon_en = 1'b0, seen_data;
    int exp_seq, data_seen, data_err, frm_out, post_frm, run, max_run, bad_act, bad_exp;

    always @(negedge rclk) begin
        if (mon_en) begin
            if (rx_stat == ST_SPECIAL && rx_data == K28_5) begin
                frm_out++;
                if (seen_data) begin
                    post_frm++;
                    run++;
                    if (run > max_run) max_run = run;
                end
            end else begin
                seen_data = 1'b1;
                run = 0;
                if (rx_stat != ST_DATA || rx_data != 8'(exp_seq)) begin
                    if (data_err == 0) begin
                        bad_act = int'({rx_stat, rx_data});
                        bad_exp = exp_seq & 8'hFF;
                    end
                    data_err++;
                end
                data_seen++;
                exp_seq++;
            end
        end
    end

    task automatic do_reset(input real rh, input bit byp);
        mon_en = 1'b0; wr_en = 1'b0; wr_data = '0; wr_stat = '0;
        wr_rst = 1'b1; rd_rst = 1'b1; bypass = byp; rhalf = rh;
        repeat (12) @(negedge wclk);
        seen_data = 1'b0; exp_seq = 0; data_seen = 0; data_err = 0;
        frm_out = 0; post_frm = 0; run = 0; max_run = 0; bad_act = 0; bad_exp = 0;
        wr_rst = 1'b0;
        @(negedge rclk);
        rd_rst = 1'b0;
        @(posedge rclk);
        mon_en = 1'b1;
    endtask

    int frm_in, n_data, byp_err;
    bit ovf_end, unf_end;

    task automatic stream(input int n, input int fe, input bit chk_byp);
        eb_char_t prev, c;
        int seq;
        seq = 0; frm_in = 0; n_data = 0; byp_err = 0; prev = FILL_CHAR;
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            if (chk_byp && i > 0 && {rx_stat, rx_data} != prev) byp_err++;
            if (fe != 0 && (i % fe) == 0) begin
                c = FILL_CHAR;
                frm_in++;
            end else begin
                c = '{stat: ST_DATA, data: 8'(seq)};
                seq++;
                n_data++;
            end
            wr_data = c.data; wr_stat = c.stat; wr_en = 1'b1;
            prev = c;
        end
        @(negedge wclk);
        if (chk_byp && {rx_stat, rx_data} != prev) byp_err++;
        ovf_end = ovf_err;
        unf_end = unf_err;
        wr_en = 1'b0;
        mon_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R2: state while reset is held
        wr_rst = 1'b1; rd_rst = 1'b1; wr_en = 1'b0; bypass = 1'b0;
        wr_data = '0; wr_stat = '0;
        repeat (12) @(negedge wclk);
        chk({rx_stat, rx_data} == FILL_CHAR, "R2", "reset output",
            int'({rx_stat, rx_data}), int'(FILL_CHAR));
        chk(ovf_err == 1'b0, "R2", "reset ovf_err", int'(ovf_err), 0);
        chk(unf_err == 1'b0, "R2", "reset unf_err", int'(unf_err), 0);

        // R1: equal rates, framing every 4th character
        do_reset(2.5, 1'b0);
        stream(2000, 4, 1'b0);
        chk(data_err == 0, "R1", "equal-rate data order", bad_act, bad_exp);
        chk(data_seen >= n_data - 12, "R1", "equal-rate data count", data_seen, n_data);
        chk(!ovf_end, "R1", "equal-rate ovf_err", int'(ovf_end), 0);
        chk(!unf_end, "R1", "equal-rate unf_err", int'(unf_end), 0);

        // R3: read slower, framing every 2nd character
        do_reset(2.7, 1'b0);
        stream(3000, 2, 1'b0);
        chk(data_err == 0, "R3", "slow-read data order", bad_act, bad_exp);
        chk(data_seen >= n_data - 12, "R3", "slow-read data count", data_seen, n_data);
        chk(!ovf_end, "R3", "deletion prevents overflow", int'(ovf_end), 0);
        chk(frm_out < frm_in, "R3", "framing out below framing in", frm_out, frm_in);

        // R4: read faster, framing every 2nd character
        do_reset(2.4, 1'b0);
        stream(3000, 2, 1'b0);
        chk(data_err == 0, "R4", "fast-read data order", bad_act, bad_exp);
        chk(data_seen >= n_data - 12, "R4", "fast-read data count", data_seen, n_data);
        chk(!unf_end, "R4", "insertion prevents underflow", int'(unf_end), 0);
        chk(frm_out > frm_in + NOM, "R4", "framing out above framing in", frm_out, frm_in);
        chk(max_run <= 2, "R4", "one insertion per head", max_run, 2);

        // R5: read slower, no framing at all
        do_reset(3.0, 1'b0);
        stream(600, 0, 1'b0);
        chk(ovf_end, "R5", "overflow flagged", int'(ovf_end), 1);
        repeat (300) @(negedge wclk);
        chk(ovf_err == 1'b1, "R5", "overflow flag sticky", int'(ovf_err), 1);

        // R6: read faster, no framing at all
        do_reset(2.0, 1'b0);
        stream(600, 0, 1'b0);
        chk(unf_end, "R6", "underflow flagged", int'(unf_end), 1);
        chk(post_frm > 0, "R6", "filler emitted on underflow", post_frm, 1);
        chk(!ovf_end, "R6", "no overflow on fast read", int'(ovf_end), 0);

        // R7: bypass with no framing and a slow read clock
        do_reset(3.0, 1'b1);
        stream(500, 0, 1'b1);
        chk(byp_err == 0, "R7", "bypass pass-through", byp_err, 0);
        chk(!ovf_end, "R7", "bypass ovf_err", int'(ovf_end), 0);
        chk(!unf_end, "R7", "bypass unf_err", int'(unf_end), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule